// File: doc/BRIEF.md
# Nonvolatile Settings Refresh Sequencer

This block moves settings between a small nonvolatile store and the wiper registers of a multi-channel digital potentiometer. When power-on reset is released, it first drives every wiper to midscale. It then reloads each channel from its stored word, one channel at a time, lowest channel first. A restore command or a soft-reset command runs the same reload later on demand. A store command copies the present wiper setting of one channel into the store, and the block then stays busy for a programmable number of cycles to model the cell programming time.

The store also holds a set of general-purpose user bytes, which can be written and read. It holds one tolerance word, which can only be read. Writes of any kind are refused while the active-low protect input is low, and also during a lockout window that follows power-on reset or a soft reset. The store is reached through a plain address, read-data, write-strobe and write-data port. Wipers are updated through a per-channel load strobe that comes with a shared value bus. Commands are single-cycle requests that have no handshake.

Top module: `nv_refresh_seq`

## Requirements
- R1: After reset is released, the first cycle loads nothing. In the second cycle, `wip_load` is high on every channel and `wip_val` equals midscale, 2^(WW-1).
- R2: Channels are reloaded in ascending order in back-to-back slots of RESTORE_CYC cycles each. In the last cycle of slot k, only `wip_load[k]` is high, `nv_addr` is k, and `wip_val` holds the low WW bits of `nv_rdata`.
- R3: `busy` is high during reset and for every cycle of a restore, store or read. In the cycle after the last channel load, or after the last cycle of a store, `busy` is low and `done` is high for exactly one cycle.
- R4: An accepted store (op 2, `cmd_idx` below NCH) raises `nv_we` for one cycle in the cycle after acceptance. In that cycle `nv_addr` equals the channel index and `nv_wdata` holds that channel's slice of `wiper_in`. The store keeps `busy` high for STORE_CYC cycles. A channel index of NCH or above is refused.
- R5: For LOCK_CYC cycles after reset is released, and after an accepted soft reset, a store or a user write is refused. A refused command raises `deny` for one cycle in the following cycle and causes no write.
- R6: While `wp_n` is low, a store or a user write is refused in the same way.
- R7: User byte j, for j below NUSER, occupies storage word NCH+j. A user write (op 3) stores `cmd_data` there. A user read (op 4) makes `busy` high for one cycle, during which `rd_valid` is high, `nv_addr` is NCH+j and `rd_data` is `nv_rdata`. An index of NUSER or above is refused for both the write and the read.
- R8: A tolerance read (op 5) returns storage word NCH+NUSER in the same way as a user read. No command writes that word.
- R9: A non-idle command (ops 1 to 6) that arrives while `busy` is high is dropped and raises `err` for one cycle in the following cycle.
- R10: A restore (op 1) reloads all channels without the midscale step and leaves the lockout untouched. A soft reset (op 6) performs the same reload and also restarts the lockout window.
- R11: Ops 0 and 7 do nothing at any time and never raise `err` or `deny`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wp_n | input | 1 | Active-low write protect |
| cmd_valid | input | 1 | Command request strobe |
| cmd_op | input | 3 | Command code |
| cmd_idx | input | IW | Channel or user-byte index |
| cmd_data | input | DW | Data for user write |
| wiper_in | input | NCH*WW | Present wiper settings, channel k at bits k*WW |
| busy | output | 1 | Sequencer occupied |
| done | output | 1 | One-cycle end of restore or store |
| err | output | 1 | Command dropped because busy |
| deny | output | 1 | Command refused (protect, lockout, index) |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DW | Read data |
| nv_addr | output | AW | Storage word address |
| nv_we | output | 1 | Storage write strobe |
| nv_wdata | output | DW | Storage write data |
| nv_rdata | input | DW | Storage read data, combinational on nv_addr |
| wip_load | output | NCH | Per-channel wiper load strobe |
| wip_val | output | WW | Wiper load value |

## Verification
The bench builds the block with three channels, so that one channel sits between the first and the last reload slot. It uses a four-cycle restore slot, a twenty-cycle store and a sixty-cycle lockout, which makes the lockout outlast a complete power-on reload. As a result, a store issued straight after power-on lands inside the lockout, while a store issued after a plain restore command lands outside it. With twelve user bytes and a four-bit index, indices twelve to fifteen exercise the out-of-range refusal for user bytes, and index three exercises it for channels.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_RESTORE = 3'd1,
    OP_STORE   = 3'd2,
    OP_UWR     = 3'd3,
    OP_URD     = 3'd4,
    OP_TOL     = 3'd5,
    OP_RESET   = 3'd6,
    OP_SPARE   = 3'd7
  } nvs_op_e;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_PRESET,
    ST_LOAD,
    ST_PROG,
    ST_READ,
    ST_IDLE
  } nvs_state_e;

  typedef enum logic [2:0] {
    K_NONE,
    K_RESTORE,
    K_RESET,
    K_WRITE,
    K_READ,
    K_DENY
  } nvs_kind_e;

  // storage word that holds user byte sel
  function automatic int unsigned user_slot(int unsigned nch, int unsigned sel);
    return nch + sel;
  endfunction

  // storage word that holds the tolerance value
  function automatic int unsigned tol_slot(int unsigned nch, int unsigned nuser);
    return nch + nuser;
  endfunction

  // midscale code for a wiper of the given width
  function automatic int unsigned mid_code(int unsigned ww);
    return 1 << (ww - 1);
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nvs_lock_timer.sv
module nvs_lock_timer #(
  parameter int LOCK_CYC = 54000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic locked
);
  localparam int LW = (LOCK_CYC < 1) ? 1 : $clog2(LOCK_CYC + 1);

  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= LW'(LOCK_CYC);
    else if (restart)        cnt_q <= LW'(LOCK_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign locked = (cnt_q != '0);

  // R5: once the window has closed it stays closed until a restart
  a_r5_lock_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !locked) |=> !locked);

endmodule

// File: rtl/nvs_step_timer.sv
module nvs_step_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start)         cnt_q <= len - 1'b1;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);

  // R3: an expired slot stays expired until restarted
  a_r3_expire_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && expire) |=> expire);

endmodule

// File: rtl/nvs_cmd_check.sv
module nvs_cmd_check
  import nvs_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int NUSER = 12,
  parameter int WW    = 8,
  parameter int DW    = 8,
  parameter int AW    = 4,
  parameter int IW    = 4
) (
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [IW-1:0]   cmd_idx,
  input  logic [DW-1:0]   cmd_data,
  input  logic [NCH*WW-1:0] wiper_in,
  input  logic            idle,
  input  logic            locked,
  input  logic            wp_n,
  output nvs_kind_e       kind,
  output logic [AW-1:0]   addr,
  output logic [DW-1:0]   wdata,
  output logic            busy_hit
);
  logic [WW-1:0] wip [NCH];
  logic [WW-1:0] sel_w;
  nvs_op_e       op;
  logic          active, wr_ok, ch_ok, user_ok;

  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    assign wip[g] = wiper_in[g*WW +: WW];
  end

  always_comb begin
    sel_w = '0;
    for (int k = 0; k < NCH; k++) begin
      if (int'(cmd_idx) == k) sel_w = wip[k];
    end
  end

  assign op       = nvs_op_e'(cmd_op);
  assign active   = cmd_valid && (op != OP_NOP) && (op != OP_SPARE);
  assign busy_hit = active && !idle;
  assign wr_ok    = wp_n && !locked;
  assign ch_ok    = int'(cmd_idx) < NCH;
  assign user_ok  = int'(cmd_idx) < NUSER;

  always_comb begin
    kind  = K_NONE;
    addr  = '0;
    wdata = '0;
    if (active && idle) begin
      case (op)
        OP_RESTORE: kind = K_RESTORE;
        OP_RESET:   kind = K_RESET;
        OP_STORE: begin
          if (ch_ok && wr_ok) begin
            kind  = K_WRITE;
            addr  = AW'(cmd_idx);
            wdata = DW'(sel_w);
          end else begin
            kind = K_DENY;
          end
        end
        OP_UWR: begin
          if (user_ok && wr_ok) begin
            kind  = K_WRITE;
            addr  = AW'(user_slot(NCH, int'(cmd_idx)));
            wdata = cmd_data;
          end else begin
            kind = K_DENY;
          end
        end
        OP_URD: begin
          if (user_ok) begin
            kind = K_READ;
            addr = AW'(user_slot(NCH, int'(cmd_idx)));
          end else begin
            kind = K_DENY;
          end
        end
        OP_TOL: begin
          kind = K_READ;
          addr = AW'(tol_slot(NCH, NUSER));
        end
        default: kind = K_NONE;
      endcase
    end
  end

endmodule

// File: rtl/nv_refresh_seq.sv
module nv_refresh_seq
  import nvs_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int NUSER       = 12,
  parameter int WW          = 8,
  parameter int DW          = 8,
  parameter int RESTORE_CYC = 15000,
  parameter int STORE_CYC   = 2600000,
  parameter int LOCK_CYC    = 54000,
  localparam int AW         = $clog2(NCH + NUSER + 1),
  localparam int IW         = (max2(NCH, NUSER) < 2) ? 1 : $clog2(max2(NCH, NUSER))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [IW-1:0]     cmd_idx,
  input  logic [DW-1:0]     cmd_data,
  input  logic [NCH*WW-1:0] wiper_in,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              deny,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic [AW-1:0]     nv_addr,
  output logic              nv_we,
  output logic [DW-1:0]     nv_wdata,
  input  logic [DW-1:0]     nv_rdata,
  output logic [NCH-1:0]    wip_load,
  output logic [WW-1:0]     wip_val
);
  localparam int CHW = (NCH < 2) ? 1 : $clog2(NCH);
  localparam int CW  = $clog2(max2(RESTORE_CYC, STORE_CYC) + 1);
  localparam logic [WW-1:0] MID = WW'(mid_code(WW));
  localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);

  nvs_state_e     state_q;
  logic [CHW-1:0] ch_q;
  logic           first_q;
  logic [AW-1:0]  pend_addr_q;
  logic [DW-1:0]  pend_data_q;

  // named internal events
  nvs_kind_e      kind;
  logic [AW-1:0]  dec_addr;
  logic [DW-1:0]  dec_wdata;
  logic           busy_hit;
  logic           locked;
  logic           t_start, t_expire;
  logic [CW-1:0]  t_len;
  logic           slot_end, last_slot, reload_req;

  assign busy       = (state_q != ST_IDLE);
  assign slot_end   = (state_q == ST_LOAD) && t_expire;
  assign last_slot  = (ch_q == LAST_CH);
  assign reload_req = (kind == K_RESTORE) || (kind == K_RESET);

  nvs_cmd_check #(
    .NCH(NCH), .NUSER(NUSER), .WW(WW), .DW(DW), .AW(AW), .IW(IW)
  ) u_check (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_idx   (cmd_idx),
    .cmd_data  (cmd_data),
    .wiper_in  (wiper_in),
    .idle      (!busy),
    .locked    (locked),
    .wp_n      (wp_n),
    .kind      (kind),
    .addr      (dec_addr),
    .wdata     (dec_wdata),
    .busy_hit  (busy_hit)
  );

  nvs_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (kind == K_RESET),
    .locked  (locked)
  );

  // one timer serves both the reload slots and the programming window
  assign t_start = (state_q == ST_PRESET) || (slot_end && !last_slot) ||
                   reload_req || (kind == K_WRITE);
  assign t_len   = (kind == K_WRITE) ? CW'(STORE_CYC) : CW'(RESTORE_CYC);

  nvs_step_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (t_start),
    .len    (t_len),
    .expire (t_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_BOOT;
      ch_q        <= '0;
      first_q     <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      done        <= 1'b0;
      err         <= 1'b0;
      deny        <= 1'b0;
    end else begin
      done    <= 1'b0;
      err     <= busy_hit;
      deny    <= (kind == K_DENY);
      first_q <= 1'b0;
      case (state_q)
        ST_BOOT:   state_q <= ST_PRESET;
        ST_PRESET: begin
          state_q <= ST_LOAD;
          ch_q    <= '0;
        end
        ST_LOAD: begin
          if (t_expire) begin
            if (last_slot) begin
              state_q <= ST_IDLE;
              done    <= 1'b1;
            end else begin
              ch_q <= ch_q + 1'b1;
            end
          end
        end
        ST_PROG: begin
          if (t_expire) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end
        end
        ST_READ:   state_q <= ST_IDLE;
        default: begin
          case (kind)
            K_RESTORE, K_RESET: begin
              state_q <= ST_LOAD;
              ch_q    <= '0;
            end
            K_WRITE: begin
              state_q     <= ST_PROG;
              first_q     <= 1'b1;
              pend_addr_q <= dec_addr;
              pend_data_q <= dec_wdata;
            end
            K_READ: begin
              state_q     <= ST_READ;
              pend_addr_q <= dec_addr;
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      endcase
    end
  end

  // wiper load port
  for (genvar g = 0; g < NCH; g++) begin : g_load
    assign wip_load[g] = (state_q == ST_PRESET) || (slot_end && (ch_q == CHW'(g)));
  end
  assign wip_val = (state_q == ST_PRESET) ? MID : nv_rdata[WW-1:0];

  // storage port
  always_comb begin
    case (state_q)
      ST_LOAD:          nv_addr = AW'(ch_q);
      ST_PROG, ST_READ: nv_addr = pend_addr_q;
      default:          nv_addr = '0;
    endcase
  end
  assign nv_we    = (state_q == ST_PROG) && first_q;
  assign nv_wdata = pend_data_q;
  assign rd_valid = (state_q == ST_READ);
  assign rd_data  = nv_rdata;

  // R3: done only ever shows with the block idle
  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9: err follows a busy cycle
  a_r9_err_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(busy));
  // R5: refusals are made from idle only
  a_r5_deny_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    deny |-> $past(!busy));
  // R6: a write strobe needs protect released at acceptance
  a_r6_write_needs_wp: assert property (@(posedge clk) disable iff (!rst_n)
    nv_we |-> $past(wp_n));
  // R5: a write strobe needs the lockout closed at acceptance
  a_r5_write_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    nv_we |-> $past(!locked));
  // R4: the write strobe is a single pulse
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    nv_we |=> !nv_we);
  // R2: outside the preset step at most one channel loads
  a_r2_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_PRESET) |-> $onehot0(wip_load));
  // R7: a read never overlaps a load
  a_r7_read_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (wip_load == '0));

endmodule

// File: tb/nv_refresh_seq_bench.sv
module nv_refresh_seq_bench;
  localparam int NCH   = 3;
  localparam int NUSER = 12;
  localparam int WW    = 8;
  localparam int DW    = 8;
  localparam int RC    = 4;
  localparam int SC    = 20;
  localparam int LOCK  = 60;
  localparam int IW    = 4;
  localparam int AW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [IW-1:0] cmd_idx = '0;
  logic [DW-1:0] cmd_data = '0;
  logic [NCH*WW-1:0] wiper_in = {8'h2B, 8'h77, 8'h19};
  logic busy, done, err, deny, rd_valid, nv_we;
  logic [DW-1:0] rd_data, nv_wdata, nv_rdata;
  logic [AW-1:0] nv_addr;
  logic [NCH-1:0] wip_load;
  logic [WW-1:0] wip_val;

  logic [7:0] mem [0:15];
  assign nv_rdata = mem[nv_addr];
  always @(posedge clk) if (nv_we) mem[nv_addr] <= nv_wdata;

  always #4 clk = ~clk;

  nv_refresh_seq #(
    .NCH(NCH), .NUSER(NUSER), .WW(WW), .DW(DW),
    .RESTORE_CYC(RC), .STORE_CYC(SC), .LOCK_CYC(LOCK)
  ) u_nv_refresh_seq (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
    .wiper_in(wiper_in), .busy(busy), .done(done), .err(err),
    .deny(deny), .rd_valid(rd_valid), .rd_data(rd_data),
    .nv_addr(nv_addr), .nv_we(nv_we), .nv_wdata(nv_wdata),
    .nv_rdata(nv_rdata), .wip_load(wip_load), .wip_val(wip_val)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // behavioural reference: phase 0 boot,1 preset,2 reload,3 program,4 read,5 idle
  int m_ph, m_ch, m_left, m_lock, m_raddr, m_saddr, m_sdata;
  bit m_first, m_done, m_err, m_deny;
  int mo, mlk;
  bit mact, midle;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_ch = 0; m_left = 0; m_lock = LOCK; m_first = 0;
      m_done = 0; m_err = 0; m_deny = 0; m_raddr = 0; m_saddr = 0; m_sdata = 0;
    end else begin
      mo    = cmd_valid ? int'(cmd_op) : 0;
      mact  = (mo >= 1) && (mo <= 6);
      midle = (m_ph == 5);
      mlk   = m_lock;
      m_done = 0; m_deny = 0; m_first = 0;
      m_err  = mact && !midle;
      if (m_lock > 0) m_lock--;
      case (m_ph)
        0: m_ph = 1;
        1: begin m_ph = 2; m_ch = 0; m_left = RC; end
        2: if (m_left == 1) begin
             if (m_ch == NCH - 1) begin m_ph = 5; m_done = 1; end
             else begin m_ch++; m_left = RC; end
           end else m_left--;
        3: if (m_left == 1) begin m_ph = 5; m_done = 1; end else m_left--;
        4: m_ph = 5;
        default: if (mact) begin
          case (mo)
            1: begin m_ph = 2; m_ch = 0; m_left = RC; end
            6: begin m_ph = 2; m_ch = 0; m_left = RC; m_lock = LOCK; end
            2: if (int'(cmd_idx) < NCH && wp_n && mlk == 0) begin
                 m_ph = 3; m_left = SC; m_first = 1; m_saddr = int'(cmd_idx);
                 m_sdata = int'(wiper_in[int'(cmd_idx)*8 +: 8]);
               end else m_deny = 1;
            3: if (int'(cmd_idx) < NUSER && wp_n && mlk == 0) begin
                 m_ph = 3; m_left = SC; m_first = 1;
                 m_saddr = NCH + int'(cmd_idx); m_sdata = int'(cmd_data);
               end else m_deny = 1;
            4: if (int'(cmd_idx) < NUSER) begin
                 m_ph = 4; m_raddr = NCH + int'(cmd_idx);
               end else m_deny = 1;
            default: begin m_ph = 4; m_raddr = NCH + NUSER; end
          endcase
        end
      endcase
    end
  end

  int load_q[$];
  int preset_cnt = 0;
  int last_rd = -1;

  always @(negedge clk) begin
    int e_load, e_val;
    if (!rst_n) begin
      chk(busy == 1'b1, "R3 reset busy", busy, 1);
      chk({done, err, deny, nv_we, rd_valid} == 5'b0, "R3 reset pulses",
          {done, err, deny, nv_we, rd_valid}, 0);
    end else begin
      e_load = 0;
      if (m_ph == 1) e_load = (1 << NCH) - 1;
      else if (m_ph == 2 && m_left == 1) e_load = 1 << m_ch;
      e_val = (m_ph == 1) ? 128 : int'(mem[m_ch]);
      chk(busy == (m_ph != 5), "R3 busy", busy, m_ph != 5);
      chk(done == m_done, "R3 done", done, m_done);
      chk(err == m_err, "R9 R11 err", err, m_err);
      chk(deny == m_deny, "R5 R6 R7 R11 deny", deny, m_deny);
      chk(int'(wip_load) == e_load, "R1 R2 R10 wip_load", wip_load, e_load);
      if (e_load != 0) chk(int'(wip_val) == e_val, "R1 R2 wip_val", wip_val, e_val);
      if (m_ph == 2 && m_left == 1)
        chk(int'(nv_addr) == m_ch, "R2 nv_addr", nv_addr, m_ch);
      chk(nv_we == (m_ph == 3 && m_first), "R4 R8 nv_we", nv_we, m_ph == 3 && m_first);
      if (m_ph == 3 && m_first) begin
        chk(int'(nv_addr) == m_saddr, "R4 R7 write addr", nv_addr, m_saddr);
        chk(int'(nv_wdata) == m_sdata, "R4 R7 write data", nv_wdata, m_sdata);
      end
      chk(rd_valid == (m_ph == 4), "R7 R8 rd_valid", rd_valid, m_ph == 4);
      if (m_ph == 4) begin
        chk(int'(rd_data) == int'(mem[m_raddr]), "R7 R8 rd_data", rd_data, mem[m_raddr]);
        last_rd = int'(rd_data);
      end
      if (wip_load == '1) preset_cnt++;
      else for (int k = 0; k < NCH; k++) if (wip_load[k]) load_q.push_back(k);
    end
  end

  task automatic send(input int op, input int idx, input int data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_idx = IW'(idx); cmd_data = DW'(data);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic check_order(input string tag);
    chk(load_q.size() == NCH, tag, load_q.size(), NCH);
    for (int k = 0; k < load_q.size(); k++) chk(load_q[k] == k, tag, load_q[k], k);
    load_q.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'(i * 3 + 1);
    mem[0] = 8'h11; mem[1] = 8'hA5; mem[2] = 8'h3C; mem[15] = 8'h5D;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_idle();
    chk(preset_cnt == 1, "R1 single preset", preset_cnt, 1);
    check_order("R2 power-on order");
    // R5: store inside the lockout
    send(2, 1, 0);
    chk(mem[1] == 8'hA5, "R5 lockout keeps word", mem[1], 8'hA5);
    send(3, 0, 8'hEE);
    chk(mem[3] == 8'h0A, "R5 lockout keeps user byte", mem[3], 8'h0A);
    repeat (LOCK) @(negedge clk);
    // R6: write protect
    wp_n = 1'b0;
    send(2, 0, 0);
    repeat (2) @(negedge clk);
    chk(mem[0] == 8'h11, "R6 protect keeps word", mem[0], 8'h11);
    wp_n = 1'b1;
    // R4 store, R9 busy refusal, R11 ignored ops while busy
    send(2, 1, 0);
    send(4, 0, 0);
    send(0, 0, 0);
    send(7, 0, 0);
    wait_idle();
    chk(mem[1] == 8'h77, "R4 stored wiper", mem[1], 8'h77);
    send(2, 3, 0);
    // R7 user bytes
    send(3, 5, 8'hC3);
    wait_idle();
    send(4, 5, 0);
    wait_idle();
    chk(last_rd == 8'hC3, "R7 user readback", last_rd, 8'hC3);
    send(4, 13, 0);
    send(3, 12, 8'h44);
    repeat (2) @(negedge clk);
    chk(mem[15] == 8'h5D, "R8 tolerance untouched", mem[15], 8'h5D);
    send(5, 0, 0);
    wait_idle();
    chk(last_rd == 8'h5D, "R8 tolerance read", last_rd, 8'h5D);
    // R10 restore: no preset, lockout untouched
    send(1, 0, 0);
    wait_idle();
    chk(preset_cnt == 1, "R10 no preset on restore", preset_cnt, 1);
    check_order("R10 restore order");
    wiper_in[7:0] = 8'h66;
    send(2, 0, 0);
    wait_idle();
    chk(mem[0] == 8'h66, "R10 store after restore", mem[0], 8'h66);
    // R10 soft reset restarts lockout
    send(6, 0, 0);
    wait_idle();
    check_order("R10 soft reset order");
    wiper_in[7:0] = 8'h55;
    send(2, 0, 0);
    repeat (2) @(negedge clk);
    chk(mem[0] == 8'h66, "R10 lockout after soft reset", mem[0], 8'h66);
    send(7, 0, 0);
    repeat (LOCK) @(negedge clk);
    send(2, 0, 0);
    wait_idle();
    chk(mem[0] == 8'h55, "R5 store after window", mem[0], 8'h55);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule